// File: doc/BRIEF.md
# Cached Hash Tree Memory Verifier

This block guards a small region of untrusted memory with a binary hash tree. The memory holds every node of the tree in heap order. Node 1 is the root, node i has children 2i and 2i+1, and the data word of leaf a is stored directly at node LEAVES+a. The root hash never leaves the block: it sits in a trusted register. A small trusted cache holds the hashes of internal nodes that were checked recently. A read fetches the leaf. It then fetches one sibling per level, recomputes each parent as the mix of its left and right child, and compares the result with a trusted value. The walk ends at the first cached node or at the root. Because the check is anchored on trusted state and not on a tag stored beside the data, a stale word copied back into memory is caught.

A write first checks the old leaf. This check always climbs to the root, so every sibling it collects is known to be genuine. The block then writes the new leaf and every recomputed ancestor back into memory, refreshes the cached copies and replaces the trusted root. A mismatch found during any check ends the command with the tamper flag, and the command leaves memory, cache and root unchanged.

The controller has these states:
- `ST_IDLE` accepts a command and issues the leaf read.
- `ST_LEAF_RD` captures the leaf.
- `ST_CHECK` compares with the root or with the cache, or issues a sibling read.
- `ST_SIB_RD` folds the sibling into the parent hash.
- `ST_WRBACK` installs hashes and, for a write, stores the new path.
- `ST_REPORT_OK` or `ST_REPORT_BAD` drives one done cycle and then returns to `ST_IDLE`.

Transitions:
- `ST_IDLE` goes to `ST_LEAF_RD` on `cmd_valid`.
- `ST_LEAF_RD` goes to `ST_CHECK`.
- `ST_CHECK` goes to `ST_SIB_RD` to climb.
- `ST_CHECK` goes to `ST_WRBACK` on a root match, or on a cache match during a read.
- `ST_CHECK` goes to `ST_REPORT_BAD` on any mismatch.
- `ST_SIB_RD` goes to `ST_CHECK`.
- `ST_WRBACK` goes to `ST_REPORT_OK` at its last level.

Top module: `hash_tree_verifier`

## Requirements
- R1: After reset the cache is empty and the trusted root equals the root of a tree whose leaves are all zero. A read of any leaf of that tree returns 0 without tamper and issues DEPTH+1 memory reads.
- R2: Memory reads return data one cycle after `mem_re`, and a read and a write never share a cycle. A parent is mix(left, right) = ((rotl(left,3) + right) XOR rotl(right,7)) + 0xAAAA on 16-bit words, where left is the even-numbered child.
- R3: A read with no cached ancestor fetches the leaf and DEPTH siblings, then compares the recomputed root with the trusted root.
- R4: Every node in the cache counts as verified. After a successful command, each computed non-root path node is installed in slot (index mod CACHE_ENTRIES). A later read whose parent is cached issues exactly 2 memory reads. A failed command installs nothing.
- R5: A leaf word altered in memory makes the next read of it end with done and tamper together, with no memory write.
- R6: Copying an earlier, once-valid value of a leaf back into memory makes a read of that leaf report tamper.
- R7: An internal node altered in memory is flagged when a walk reads it as a sibling.
- R8: A write that checks clean issues DEPTH+1 reads and DEPTH writes, leaf first. Afterwards every internal node in memory equals the mix of its children, and a read returns the new data.
- R9: A write that finds tamper writes nothing to memory and leaves the root unchanged. After the memory is repaired, reads pass again.
- R10: Each command yields a single-cycle `done`, during which no memory access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | DEPTH | Leaf number |
| cmd_wdata | input | 16 | Data to write |
| done | output | 1 | One-cycle completion pulse |
| tamper | output | 1 | Integrity failure, valid with done |
| rdata | output | 16 | Leaf data read, valid with done when tamper is low |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | DEPTH+1 | Node index |
| mem_wdata | output | 16 | Node value to write |
| mem_rdata | input | 16 | Node value, one cycle after mem_re |

## Verification
A wrong cached hash shows up at the ports as a false tamper on the next read whose walk reaches that slot. A wrong root shows up the same way on the next walk that climbs to the top. A lost write-back shows as an inconsistent node in memory right after the write completes, and as a tamper flag on the following read that uses it. The count of memory reads per command exposes a faulty early stop within one command: a stop that fires wrongly skips sibling fetches, and a stop that never fires keeps climbing. An unwanted cache fill after a failure shows on the very next read as a shorter walk.

// File: rtl/htv_pkg.sv
package htv_pkg;
    localparam int HASH_W = 16;
    typedef logic [HASH_W-1:0] hash_t;
    localparam hash_t MIX_K = {(HASH_W/2){2'b10}};

    function automatic hash_t rotl(hash_t v, int unsigned s);
        return (v << s) | (v >> (HASH_W - s));
    endfunction

    // compression of two child hashes, left child first
    function automatic hash_t mix(hash_t l, hash_t r);
        return ((rotl(l, 3) + r) ^ rotl(r, 7)) + MIX_K;
    endfunction

    // root of a tree whose leaves are all zero
    function automatic hash_t empty_root(int unsigned depth);
        hash_t z;
        z = '0;
        for (int unsigned k = 0; k < depth; k++) z = mix(z, z);
        return z;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAF_RD,
        ST_CHECK,
        ST_SIB_RD,
        ST_WRBACK,
        ST_REPORT_OK,
        ST_REPORT_BAD
    } htv_state_e;
endpackage

// File: rtl/htv_mix.sv
module htv_mix
    import htv_pkg::*;
(
    input  hash_t a,
    input  hash_t b,
    output hash_t y
);
    assign y = mix(a, b);
endmodule

// File: rtl/htv_node_cache.sv
module htv_node_cache
    import htv_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDXW    = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] lk_idx,
    output logic            lk_hit,
    output hash_t           lk_val,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  hash_t           wr_val
);
    localparam int SLOTW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] hit_vec;
    hash_t              dat_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic            vld;
        logic [IDXW-1:0] tag;
        hash_t           dat;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= 1'b0;
                tag <= '0;
                dat <= '0;
            end else if (wr_en && (wr_idx[SLOTW-1:0] == SLOTW'(g))) begin
                vld <= 1'b1;
                tag <= wr_idx;
                dat <= wr_val;
            end
        end

        assign hit_vec[g] = vld && (tag == lk_idx);
        assign dat_arr[g] = dat;
    end

    // a node can only live in its own slot, so any tag match is the hit
    assign lk_hit = |hit_vec;
    assign lk_val = dat_arr[lk_idx[SLOTW-1:0]];
endmodule

// File: rtl/hash_tree_verifier.sv
module hash_tree_verifier
    import htv_pkg::*;
#(
    parameter int DEPTH         = 4,
    parameter int CACHE_ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic [DEPTH-1:0]   cmd_addr,
    input  logic [HASH_W-1:0]  cmd_wdata,
    output logic               done,
    output logic               tamper,
    output logic [HASH_W-1:0]  rdata,
    output logic               mem_re,
    output logic               mem_we,
    output logic [DEPTH:0]     mem_addr,
    output logic [HASH_W-1:0]  mem_wdata,
    input  logic [HASH_W-1:0]  mem_rdata
);
    localparam int    IDXW      = DEPTH + 1;
    localparam int    LVLW      = $clog2(DEPTH + 1);
    localparam hash_t ROOT_INIT = empty_root(DEPTH);
    localparam logic [LVLW-1:0] TOP_LVL = LVLW'(DEPTH);

    htv_state_e state, state_nx;

    logic            op_wr;
    logic [IDXW-1:0] leaf_idx;
    logic [IDXW-1:0] cur_idx;
    hash_t           cur_val;
    hash_t           data_q;
    hash_t           wdata_q;
    hash_t           new_val;
    hash_t           root_q;
    logic [LVLW-1:0] lvl;
    logic [LVLW-1:0] wb_q;
    hash_t           sib  [DEPTH+1];
    hash_t           path [DEPTH+1];

    logic            lk_hit;
    hash_t           lk_val;
    logic            c_wr_en;
    hash_t           c_wr_val;
    logic [IDXW-1:0] node_wb;
    hash_t           up_a, up_b, up_y;
    hash_t           dn_a, dn_b, dn_y;
    logic            at_root;
    logic            climb;
    logic            chk_bad;
    logic            wb_last;

    htv_node_cache #(
        .ENTRIES (CACHE_ENTRIES),
        .IDXW    (IDXW)
    ) u_cache (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (cur_idx),
        .lk_hit (lk_hit),
        .lk_val (lk_val),
        .wr_en  (c_wr_en),
        .wr_idx (node_wb),
        .wr_val (c_wr_val)
    );

    // upward fold: sibling arriving from memory meets the running hash
    assign up_a = cur_idx[0] ? mem_rdata : cur_val;
    assign up_b = cur_idx[0] ? cur_val   : mem_rdata;
    htv_mix u_mix_up (.a(up_a), .b(up_b), .y(up_y));

    // write-back fold: new path hash meets the stored sibling
    assign node_wb = leaf_idx >> wb_q;
    assign dn_a    = node_wb[0] ? sib[wb_q] : new_val;
    assign dn_b    = node_wb[0] ? new_val   : sib[wb_q];
    htv_mix u_mix_dn (.a(dn_a), .b(dn_b), .y(dn_y));

    assign at_root = (cur_idx == IDXW'(1));
    assign climb   = !at_root && (!lk_hit || (op_wr && (lk_val == cur_val)));
    assign chk_bad = at_root ? (cur_val != root_q) : (lk_hit && (lk_val != cur_val));
    assign wb_last = (wb_q == lvl);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (cmd_valid) state_nx = ST_LEAF_RD;
            ST_LEAF_RD:    state_nx = ST_CHECK;
            ST_CHECK: begin
                if (chk_bad)    state_nx = ST_REPORT_BAD;
                else if (climb) state_nx = ST_SIB_RD;
                else            state_nx = ST_WRBACK;
            end
            ST_SIB_RD:     state_nx = ST_CHECK;
            ST_WRBACK:     if (wb_last) state_nx = ST_REPORT_OK;
            ST_REPORT_OK:  state_nx = ST_IDLE;
            ST_REPORT_BAD: state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = new_val;
        c_wr_en   = 1'b0;
        c_wr_val  = op_wr ? new_val : path[wb_q];
        done      = 1'b0;
        tamper    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mem_re   = cmd_valid;
                mem_addr = {1'b1, cmd_addr};
            end
            ST_CHECK: begin
                mem_re   = climb && !chk_bad;
                mem_addr = cur_idx ^ IDXW'(1);
            end
            ST_WRBACK: begin
                mem_addr = node_wb;
                mem_we   = op_wr && (wb_q < TOP_LVL);
                c_wr_en  = (wb_q != '0) && (wb_q < TOP_LVL);
            end
            ST_REPORT_OK:  done = 1'b1;
            ST_REPORT_BAD: begin
                done   = 1'b1;
                tamper = 1'b1;
            end
            default: ;
        endcase
    end

    assign rdata = data_q;

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr    <= 1'b0;
            leaf_idx <= '0;
            cur_idx  <= '0;
            cur_val  <= '0;
            data_q   <= '0;
            wdata_q  <= '0;
            new_val  <= '0;
            root_q   <= ROOT_INIT;
            lvl      <= '0;
            wb_q     <= '0;
            for (int i = 0; i <= DEPTH; i++) begin
                sib[i]  <= '0;
                path[i] <= '0;
            end
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    op_wr    <= cmd_write;
                    leaf_idx <= {1'b1, cmd_addr};
                    wdata_q  <= cmd_wdata;
                end
                ST_LEAF_RD: begin
                    cur_val <= mem_rdata;
                    data_q  <= mem_rdata;
                    cur_idx <= leaf_idx;
                    lvl     <= '0;
                end
                ST_CHECK: if (!chk_bad && !climb) begin
                    wb_q    <= op_wr ? LVLW'(0) : LVLW'(1);
                    new_val <= wdata_q;
                end
                ST_SIB_RD: begin
                    sib[lvl]         <= mem_rdata;
                    path[lvl + 1'b1] <= up_y;
                    cur_val          <= up_y;
                    cur_idx          <= cur_idx >> 1;
                    lvl              <= lvl + 1'b1;
                end
                ST_WRBACK: begin
                    if (wb_last) begin
                        if (op_wr) root_q <= new_val;
                    end else begin
                        new_val <= dn_y;
                        wb_q    <= wb_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/htv_chk.sv
module htv_chk #(
    parameter int DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic tamper,
    input logic mem_re,
    input logic mem_we
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(mem_re || mem_we));

    // R5
    tamper_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tamper |-> done);

    // R2
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R9
    wr_then_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !tamper);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !done && !mem_we);
endmodule

bind hash_tree_verifier htv_chk #(.DEPTH(DEPTH)) u_htv_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .tamper (tamper),
    .mem_re (mem_re),
    .mem_we (mem_we)
);

// File: tb/hash_tree_verifier_tb_top.sv
module hash_tree_verifier_tb_top;
    localparam int DEPTH = 4;
    localparam int N     = 1 << DEPTH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_write = 1'b0;
    logic [DEPTH-1:0]  cmd_addr = '0;
    logic [15:0]       cmd_wdata = '0;
    logic              done, tamper, mem_re, mem_we;
    logic [15:0]       rdata, mem_wdata;
    logic [15:0]       mem_rdata = '0;
    logic [DEPTH:0]    mem_addr;

    logic [15:0]       mem [0:2*N-1];
    logic              poke_en = 1'b0;
    logic [DEPTH:0]    poke_idx = '0;
    logic [15:0]       poke_val = '0;
    logic              init_req = 1'b1;

    logic [15:0]       shadow [N];
    int                n_vec = 0;
    int                n_bad = 0;
    int                done_cnt = 0;
    int                rd_cnt = 0;
    int                wr_cnt = 0;
    logic              prev_done = 1'b0;

    typedef struct {
        bit          chk_data;
        logic [15:0] data;
        bit          tmp;
        int          reads;
        int          writes;
        string       req;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    hash_tree_verifier #(.DEPTH(DEPTH), .CACHE_ENTRIES(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .done(done), .tamper(tamper),
        .rdata(rdata), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] tb_mix(logic [15:0] l, logic [15:0] r);
        logic [15:0] a, b;
        a = {l[12:0], l[15:13]};
        b = {r[8:0], r[15:9]};
        return ((a + r) ^ b) + 16'hAAAA;
    endfunction

    // untrusted memory model
    always @(posedge clk) begin
        if (init_req) begin
            mem[0] = '0;
            for (int i = N; i < 2*N; i++) mem[i] = '0;
            for (int i = N-1; i >= 1; i--) mem[i] = tb_mix(mem[2*i], mem[2*i+1]);
        end else begin
            if (mem_re) mem_rdata <= mem[mem_addr];
            if (mem_we) mem[mem_addr] = mem_wdata;
            if (poke_en) mem[poke_idx] = poke_val;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_re) rd_cnt++;
            if (mem_we) wr_cnt++;
            if (done) begin
                exp_t e;
                if (sbq.size() == 0) begin
                    chk(0, "R10", "unexpected done", 1, 0);
                end else begin
                    bit ok;
                    e  = sbq.pop_front();
                    ok = (tamper == e.tmp) && !prev_done;
                    if (e.chk_data) ok = ok && (rdata == e.data);
                    if (e.reads >= 0) ok = ok && (rd_cnt == e.reads);
                    if (e.writes >= 0) ok = ok && (wr_cnt == e.writes);
                    if (!ok)
                        $display("  detail %s: tamper %0d/%0d data %0h/%0h reads %0d/%0d writes %0d/%0d",
                                 e.req, tamper, e.tmp, rdata, e.data, rd_cnt, e.reads, wr_cnt, e.writes);
                    chk(ok, e.req, "op result", {15'd0, tamper, rdata}, {15'd0, e.tmp, e.data});
                end
                rd_cnt = 0;
                wr_cnt = 0;
                done_cnt++;
            end
            prev_done = done;
        end else begin
            rd_cnt = 0;
            wr_cnt = 0;
            prev_done = 1'b0;
        end
    end

    task automatic do_op(bit wr, int addr, logic [15:0] d, bit et, int er, int ew, string req);
        exp_t e;
        int target;
        e.chk_data = !wr && !et;
        e.data     = shadow[addr];
        e.tmp      = et;
        e.reads    = er;
        e.writes   = ew;
        e.req      = req;
        sbq.push_back(e);
        if (wr && !et) shadow[addr] = d;
        target = done_cnt + 1;
        @(posedge clk); #1;
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = addr[DEPTH-1:0];
        cmd_wdata = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        while (done_cnt < target) @(posedge clk);
        @(posedge clk); #1;
    endtask

    task automatic poke(int idx, logic [15:0] v);
        @(posedge clk); #1;
        poke_en  = 1'b1;
        poke_idx = idx[DEPTH:0];
        poke_val = v;
        @(posedge clk); #1;
        poke_en  = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n    = 1'b0;
        init_req = 1'b1;
        for (int i = 0; i < N; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done && !tamper && !mem_re && !mem_we, "R1", "reset outputs",
            {done, tamper, mem_re, mem_we}, 0);
        @(posedge clk); #1;
        init_req = 1'b0;
        rst_n    = 1'b1;
    endtask

    task automatic check_tree(string req);
        bit ok = 1'b1;
        for (int i = 0; i < N; i++) if (mem[N+i] != shadow[i]) ok = 1'b0;
        for (int i = 2; i < N; i++) if (mem[i] != tb_mix(mem[2*i], mem[2*i+1])) ok = 1'b0;
        chk(ok, req, "tree consistency", ok, 1);
    endtask

    initial begin
        #(200000 * 10);
        chk(0, "WATCHDOG", "timeout", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] keep;
        do_reset();
        // R1 R3: full climb on an empty cache
        do_op(0, 0, 16'h0, 0, 5, 0, "R1");
        // R4: parent of leaf 1 is now cached
        do_op(0, 1, 16'h0, 0, 2, 0, "R4");
        // R8: write always climbs to root and stores DEPTH nodes
        do_op(1, 1, 16'h1234, 0, 5, 4, "R8");
        check_tree("R2");
        do_op(0, 1, 16'h0, 0, 2, 0, "R8");
        do_op(1, 9, 16'hBEEF, 0, 5, 4, "R8");
        do_op(0, 9, 16'h0, 0, 2, 0, "R4");
        do_op(0, 8, 16'h0, 0, 2, 0, "R3");
        check_tree("R8");
        // R6: replay an older valid leaf value
        do_op(1, 5, 16'h0A0A, 0, 5, 4, "R8");
        do_op(1, 5, 16'h5555, 0, 5, 4, "R8");
        poke(N + 5, 16'h0A0A);
        do_op(0, 5, 16'h0, 1, -1, 0, "R6");
        poke(N + 5, 16'h5555);
        do_op(0, 5, 16'h0, 0, -1, 0, "R6");
        // R5 R9: corrupted leaf, then a write over it
        poke(N + 7, 16'h0001);
        do_op(0, 7, 16'h0, 1, -1, 0, "R5");
        do_op(1, 7, 16'h7777, 1, -1, 0, "R9");
        poke(N + 7, 16'h0000);
        do_op(0, 7, 16'h0, 0, -1, 0, "R9");
        check_tree("R9");
        // R7: corrupted internal sibling on a fresh cache
        do_reset();
        keep = mem[5];
        poke(5, keep ^ 16'h0100);
        do_op(0, 0, 16'h0, 1, 5, 0, "R7");
        do_op(1, 0, 16'h4321, 1, -1, 0, "R7");
        poke(5, keep);
        // R4: failed commands left the cache empty
        do_op(0, 0, 16'h0, 0, 5, 0, "R4");
        // R4: early stop never fetches the damaged node 9
        keep = mem[9];
        poke(9, keep ^ 16'h0040);
        do_op(0, 1, 16'h0, 0, 2, 0, "R4");
        poke(9, keep);
        do_op(0, 14, 16'h0, 0, 5, 0, "R3");
        // R10: done is a one-cycle pulse, confirmed by a quiet sample after it
        @(negedge clk);
        chk(!done, "R10", "done after op", done, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule